// File: doc/BRIEF.md
# Bus Initiator Address Phase Sequencer

This block is the initiator side of the address phase on a shared, multiplexed 32-bit address/data bus. A requester presents a 64-bit address, a 4-bit command and a start strobe. The sequencer raises its bus request, waits for the arbiter's grant and then drives the address and command. When the upper half of the address is nonzero it uses a two-cycle address phase. When the upper half is zero it uses a one-cycle phase.

After the last address cycle, the sequencer watches a claim input for a bounded window. A claim hands the transaction on to the data-phase logic. If no claim arrives, the sequencer ends the transaction with a master abort. An aborted read returns all-ones data to the requester. A broadcast (special) command is never claimed. For that command the sequencer holds its message word on the bus for a fixed number of cycles and then aborts.

Top module: `addr_phase_initiator`

## Requirements
- R1: The first cycle after reset shows bus request low, bus not driven, `ad_o`, `cbe_o` and `rdata_o` zero, and `done_o`, `mabort_o` and `handoff_o` low.
- R2: A start pulse seen while idle raises `busreq_o` from the next cycle. The first address cycle comes in the cycle after `grant_i` is sampled high while requesting, and never earlier.
- R3: When address bits 63:32 are all zero, the address phase is one cycle. In that cycle `ad_drive_o`=1, `ad_o` carries bits 31:0 and `cbe_o` carries the request command.
- R4: When address bits 63:32 are nonzero, the address phase is two cycles. The first cycle carries bits 31:0 with `cbe_o`=4'b1101. The next cycle carries bits 63:32 with the request command.
- R5: The claim window is the CLAIM_WIN cycles (default 5) after the last address cycle. If `claim_i` is high in any of them, the next cycle shows `done_o`=1, `handoff_o`=1 and `mabort_o`=0.
- R6: If `claim_i` stays low through the whole window, the next cycle shows `done_o`=1 and `mabort_o`=1.
- R7: In the done cycle of a master abort, `rdata_o` is 32'hFFFFFFFF for a read command (command bit 0 = 0). It is zero for a write command (bit 0 = 1). In every other cycle `rdata_o` is zero.
- R8: For command 4'b0001 (broadcast), after the address phase the sequencer drives address bits 31:0 as the message for SPEC_HOLD cycles (default 4), with `ad_drive_o`=1 and `cbe_o`=0. It ignores `claim_i` and then ends with a master abort.
- R9: `busreq_o` is low in the done cycle, and the sequencer is idle in the following cycle.
- R10: A start pulse while the sequencer is busy is ignored. The transaction in flight keeps the address and command captured when it started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| req_addr_i | input | 64 | Request address |
| req_cmd_i | input | 4 | Request command code |
| grant_i | input | 1 | Arbiter grant |
| claim_i | input | 1 | Target claim |
| busreq_o | output | 1 | Bus request to the arbiter |
| ad_drive_o | output | 1 | Sequencer is driving the address/data lines |
| ad_o | output | 32 | Multiplexed address/data value |
| cbe_o | output | 4 | Command field during address cycles, zero otherwise |
| done_o | output | 1 | Transaction ended (one cycle) |
| mabort_o | output | 1 | Transaction ended by master abort (valid with done) |
| handoff_o | output | 1 | Transaction claimed, handed to the data phase |
| rdata_o | output | 32 | Read data returned on abort |

## Verification
The hardest cases to reach are a claim on the very last slot of the window and a start pulse that arrives while the sequencer is still waiting for grant. From the ports these look much like a timely claim and an accepted start. The bench places the claim by counting cycles from the last address cycle, which it derives from the grant delay and the address width. It changes the address and command while the stray start pulses are applied, so any wrongly captured request shows up on `ad_o` in the address cycles.

// File: rtl/aps_pkg.sv
package aps_pkg;

  localparam logic [3:0] CMD_DUAL_ADDR = 4'b1101;
  localparam logic [3:0] CMD_BROADCAST = 4'b0001;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_ALO,
    ST_AHI,
    ST_WAIT,
    ST_BCAST,
    ST_HAND,
    ST_ABRT
  } aps_state_e;

  // two-cycle address only when the upper word carries information
  function automatic logic needs_two_cycles(input logic [63:0] addr);
    return |addr[63:32];
  endfunction

  function automatic logic cmd_is_read(input logic [3:0] cmd);
    return ~cmd[0];
  endfunction

  function automatic logic [31:0] abort_fill(input logic rd);
    return rd ? 32'hFFFF_FFFF : 32'h0;
  endfunction

endpackage

// File: rtl/aps_window_timer.sv
module aps_window_timer #(
  parameter int MAX_LIMIT = 5,
  localparam int CW = $clog2(MAX_LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic [CW-1:0] limit_i,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run_i) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = run_i && (cnt_q == limit_i - 1'b1);
endmodule

// File: rtl/aps_bus_mux.sv
module aps_bus_mux
  import aps_pkg::*;
#(
  parameter int DW = 32,
  localparam int AW = 2 * DW
) (
  input  aps_state_e    state_i,
  input  logic [AW-1:0] addr_i,
  input  logic [3:0]    cmd_i,
  input  logic          two_cyc_i,
  output logic [DW-1:0] ad_o,
  output logic [3:0]    cbe_o,
  output logic          drive_o
);
  always_comb begin
    ad_o    = '0;
    cbe_o   = '0;
    drive_o = 1'b0;
    unique case (state_i)
      ST_ALO: begin
        ad_o    = addr_i[DW-1:0];
        cbe_o   = two_cyc_i ? CMD_DUAL_ADDR : cmd_i;
        drive_o = 1'b1;
      end
      ST_AHI: begin
        ad_o    = addr_i[AW-1:DW];
        cbe_o   = cmd_i;
        drive_o = 1'b1;
      end
      ST_BCAST: begin
        ad_o    = addr_i[DW-1:0];
        drive_o = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/addr_phase_initiator.sv
module addr_phase_initiator
  import aps_pkg::*;
#(
  parameter int CLAIM_WIN = 5,
  parameter int SPEC_HOLD = 4,
  parameter int DW        = 32,
  localparam int AW       = 2 * DW,
  localparam int MAXL     = (CLAIM_WIN > SPEC_HOLD) ? CLAIM_WIN : SPEC_HOLD,
  localparam int CW       = $clog2(MAXL + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [3:0]    req_cmd_i,
  input  logic          grant_i,
  input  logic          claim_i,
  output logic          busreq_o,
  output logic          ad_drive_o,
  output logic [DW-1:0] ad_o,
  output logic [3:0]    cbe_o,
  output logic          done_o,
  output logic          mabort_o,
  output logic          handoff_o,
  output logic [DW-1:0] rdata_o
);
  aps_state_e    state_q, state_d;
  logic [AW-1:0] addr_q;
  logic [3:0]    cmd_q;
  logic          two_cyc, bcast, win_last;
  logic [CW-1:0] limit;

  // named events for the checker
  logic ev_addr_lo, ev_addr_hi, ev_claim_seen, ev_window_out, cur_read, is_idle;

  assign two_cyc  = needs_two_cycles(addr_q);
  assign bcast    = (cmd_q == CMD_BROADCAST);
  assign cur_read = cmd_is_read(cmd_q);
  assign is_idle  = (state_q == ST_IDLE);

  assign limit = (state_q == ST_BCAST) ? CW'(SPEC_HOLD) : CW'(CLAIM_WIN);

  aps_window_timer #(.MAX_LIMIT(MAXL)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  ((state_q == ST_WAIT) || (state_q == ST_BCAST)),
    .limit_i(limit),
    .last_o (win_last)
  );

  assign ev_addr_lo    = (state_q == ST_ALO);
  assign ev_addr_hi    = (state_q == ST_AHI);
  assign ev_claim_seen = (state_q == ST_WAIT) && claim_i;
  assign ev_window_out = (state_q == ST_WAIT) && !claim_i && win_last;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_REQ;
      ST_REQ:   if (grant_i) state_d = ST_ALO;
      ST_ALO:   state_d = two_cyc ? ST_AHI : (bcast ? ST_BCAST : ST_WAIT);
      ST_AHI:   state_d = bcast ? ST_BCAST : ST_WAIT;
      ST_WAIT: begin
        if (ev_claim_seen)      state_d = ST_HAND;
        else if (ev_window_out) state_d = ST_ABRT;
      end
      ST_BCAST: if (win_last) state_d = ST_ABRT;
      ST_HAND:  state_d = ST_IDLE;
      ST_ABRT:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      cmd_q   <= '0;
    end else begin
      state_q <= state_d;
      if (is_idle && start_i) begin
        addr_q <= req_addr_i;
        cmd_q  <= req_cmd_i;
      end
    end
  end

  aps_bus_mux #(.DW(DW)) u_mux (
    .state_i  (state_q),
    .addr_i   (addr_q),
    .cmd_i    (cmd_q),
    .two_cyc_i(two_cyc),
    .ad_o     (ad_o),
    .cbe_o    (cbe_o),
    .drive_o  (ad_drive_o)
  );

  assign busreq_o  = (state_q == ST_REQ) || (state_q == ST_ALO) || (state_q == ST_AHI)
                  || (state_q == ST_WAIT) || (state_q == ST_BCAST);
  assign handoff_o = (state_q == ST_HAND);
  assign mabort_o  = (state_q == ST_ABRT);
  assign done_o    = handoff_o || mabort_o;
  assign rdata_o   = mabort_o ? abort_fill(cur_read) : '0;
endmodule

// File: rtl/aps_checker.sv
module aps_checker #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          grant_i,
  input logic          busreq_o,
  input logic          ev_addr_lo,
  input logic          ev_addr_hi,
  input logic          is_idle,
  input logic          ad_drive_o,
  input logic [DW-1:0] ad_o,
  input logic [3:0]    cbe_o,
  input logic          done_o,
  input logic          mabort_o,
  input logic          handoff_o,
  input logic          cur_read,
  input logic [DW-1:0] rdata_o
);
  // R2
  addr_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_addr_lo |-> ($past(grant_i) && $past(busreq_o)));

  // R4
  dual_then_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_addr_lo && cbe_o == 4'b1101) |=> ev_addr_hi);

  // R3
  high_word_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_addr_hi |-> (ad_o != '0));

  // R5
  end_kind_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({handoff_o, mabort_o}));

  // R7
  abort_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && mabort_o && cur_read) |-> (rdata_o == '1));

  // R8
  bcast_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_addr_lo && cbe_o == 4'b0001) |=> (ad_drive_o && !done_o));

  // R9
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busreq_o ##1 is_idle));
endmodule

bind addr_phase_initiator aps_checker #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .grant_i   (grant_i),
  .busreq_o  (busreq_o),
  .ev_addr_lo(ev_addr_lo),
  .ev_addr_hi(ev_addr_hi),
  .is_idle   (is_idle),
  .ad_drive_o(ad_drive_o),
  .ad_o      (ad_o),
  .cbe_o     (cbe_o),
  .done_o    (done_o),
  .mabort_o  (mabort_o),
  .handoff_o (handoff_o),
  .cur_read  (cur_read),
  .rdata_o   (rdata_o)
);

// File: tb/addr_phase_initiator_tb.sv
`timescale 1ns/1ps
module addr_phase_initiator_tb;
  localparam int WIN  = 5;
  localparam int HOLD = 4;
  localparam int EW   = 73;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, grant_i = 1'b0, claim_i = 1'b0;
  logic [63:0] req_addr_i = '0;
  logic [3:0]  req_cmd_i = '0;
  logic        busreq_o, ad_drive_o, done_o, mabort_o, handoff_o;
  logic [31:0] ad_o, rdata_o;
  logic [3:0]  cbe_o;

  int errors = 0, checks = 0, cycles = 0;

  always #2 clk = ~clk;

  addr_phase_initiator #(.CLAIM_WIN(WIN), .SPEC_HOLD(HOLD)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .req_addr_i(req_addr_i),
    .req_cmd_i(req_cmd_i), .grant_i(grant_i), .claim_i(claim_i),
    .busreq_o(busreq_o), .ad_drive_o(ad_drive_o), .ad_o(ad_o), .cbe_o(cbe_o),
    .done_o(done_o), .mabort_o(mabort_o), .handoff_o(handoff_o), .rdata_o(rdata_o)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired got=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  // packed expectation: busreq, drive, ad, cbe, done, mabort, handoff, rdata
  function automatic logic [EW-1:0] ex(input logic br, input logic dr, input logic [31:0] ad,
                                       input logic [3:0] cb, input logic dn, input logic ma,
                                       input logic ho, input logic [31:0] rd);
    return {br, dr, ad, cb, dn, ma, ho, rd};
  endfunction

  function automatic logic [EW-1:0] observed();
    return {busreq_o, ad_drive_o, ad_o, cbe_o, done_o, mabort_o, handoff_o, rdata_o};
  endfunction

  task automatic check_now(input logic [EW-1:0] e, input string tag);
    checks++;
    if (observed() !== e) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, observed(), e);
    end
  endtask

  // one transaction: grant after gdel request cycles, claim in window slot cslot (-1: none)
  task automatic run_txn(input logic [63:0] a, input logic [3:0] c, input int gdel,
                         input int cslot, input bit stray, input string tag);
    logic [EW-1:0] expq[$];
    logic [2:0]    inq[$];
    logic [63:0]   alt;
    bit dual, bc, rd, claimed;
    dual = (a[63:32] != 32'h0);
    bc   = (c == 4'b0001);
    rd   = (c[0] == 1'b0);
    claimed = 1'b0;
    alt  = ~a;
    // idle cycle with start
    expq.push_back(ex(0, 0, 0, 0, 0, 0, 0, 0)); inq.push_back(3'b100);
    for (int k = 1; k <= gdel; k++) begin
      expq.push_back(ex(1, 0, 0, 0, 0, 0, 0, 0));
      inq.push_back({stray, (k == gdel), 1'b0});
    end
    expq.push_back(ex(1, 1, a[31:0], dual ? 4'b1101 : c, 0, 0, 0, 0)); inq.push_back(3'b000);
    if (dual) begin
      expq.push_back(ex(1, 1, a[63:32], c, 0, 0, 0, 0)); inq.push_back(3'b000);
    end
    if (bc) begin
      for (int k = 0; k < HOLD; k++) begin
        expq.push_back(ex(1, 1, a[31:0], 0, 0, 0, 0, 0)); inq.push_back(3'b001);
      end
    end else begin
      for (int k = 0; k < WIN && !claimed; k++) begin
        expq.push_back(ex(1, 0, 0, 0, 0, 0, 0, 0));
        inq.push_back({2'b00, (k == cslot)});
        if (k == cslot) claimed = 1'b1;
      end
    end
    if (claimed) expq.push_back(ex(0, 0, 0, 0, 1, 0, 1, 0));
    else         expq.push_back(ex(0, 0, 0, 0, 1, 1, 0, rd ? 32'hFFFF_FFFF : 32'h0));
    inq.push_back(3'b000);
    expq.push_back(ex(0, 0, 0, 0, 0, 0, 0, 0)); inq.push_back(3'b000);

    while (expq.size() > 0) begin
      logic [EW-1:0] e;
      logic [2:0]    s;
      e = expq.pop_front();
      s = inq.pop_front();
      @(negedge clk);
      check_now(e, tag);
      start_i = s[2];
      grant_i = s[1];
      claim_i = s[0];
      if (stray && s[2] && busreq_o) begin
        req_addr_i = alt;
        req_cmd_i  = ~c;
      end else begin
        req_addr_i = a;
        req_cmd_i  = c;
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_now(ex(0, 0, 0, 0, 0, 0, 0, 0), "R1 reset state");
    // single-cycle read, unclaimed: abort with all-ones
    run_txn(64'h0000_0000_1234_5678, 4'b0110, 1, -1, 0, "R2 R3 R6 R7 R9 rd abort");
    // two-cycle write, claimed mid-window
    run_txn(64'h0000_00AB_CDEF_0010, 4'b0111, 3, 2, 0, "R4 R5 R9 dual claim");
    // two-cycle read, unclaimed
    run_txn(64'h8000_0000_0000_0040, 4'b0110, 2, -1, 0, "R4 R6 R7 dual rd abort");
    // single-cycle write, unclaimed: zero read data
    run_txn(64'h0000_0000_0000_0CF8, 4'b0011, 1, -1, 0, "R6 R7 wr abort");
    // broadcast with claim held high
    run_txn(64'h0000_0000_0000_0002, 4'b0001, 2, -1, 0, "R8 broadcast");
    // claim on last window slot
    run_txn(64'h0000_0000_0000_0800, 4'b1010, 1, WIN - 1, 0, "R5 last slot");
    // claim on first window slot
    run_txn(64'h0000_0000_F000_0000, 4'b1100, 4, 0, 0, "R5 first slot");
    // stray start while waiting for grant
    run_txn(64'h0000_0000_5555_AAAA, 4'b0110, 4, -1, 1, "R10 stray start");
    run_txn(64'h0000_0001_0000_0000, 4'b1110, 2, 1, 1, "R10 R4 stray dual");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule